// File: doc/BRIEF.md
# MDIO Management Interface Controller

This block runs Clause 22 management transactions from a station to an external PHY. Software writes one 32-bit maintenance word that carries an operation code, a 5-bit PHY address, a 5-bit register address and, for a write, 16 data bits. The block accepts the word and sends one 64-bit management frame on MDC/MDIO: a preamble of 32 ones, start bits 01, the operation code, both addresses MSB first, two turnaround bits and 16 data bits. Software finds out that a transaction has finished only by polling an idle flag.

MDC comes from the system clock through a divider with a run-time half-period setting. Any value between 1 and the parameter limit is valid, and a half period of 112 clocks gives divide-by-224. A management-port enable input gates all MDC activity. On a read, the PHY's 16-bit reply appears in the low half of the same maintenance word when the frame ends.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, mdio_idle is 1, mdc is 0, mdio_oe is 0 and maint_rdata is 0.
- R2: A maint_wr pulse starts a frame only when three things hold: port_en is 1, mdio_idle is 1, and the operation field maint_wdata[29:28] is 2'b01 (write) or 2'b10 (read). mdio_idle goes low in the cycle after the pulse and stays low until the frame has ended.
- R3: A frame is exactly 64 MDC cycles long. The bits, in order, are 32 ones, 0, 1, the operation field, the PHY address maint_wdata[27:23] MSB first and the register address maint_wdata[22:18] MSB first, followed by 2 turnaround bits and 16 data bits. MDIO changes only while MDC is falling, or at the start of the frame.
- R4: On a write, the turnaround bits are 1 then 0, followed by maint_wdata[15:0] MSB first. mdio_oe is 1 for all 64 bits.
- R5: On a read, mdio_oe is 0 for the last 18 bit times. The block samples mdio_i on the MDC rising edge of each of the last 16 bits, MSB first. When mdio_idle returns to 1, the captured value is in maint_rdata[15:0], and maint_rdata[31:16] holds the written command bits.
- R6: After a write transaction, maint_rdata equals the maintenance word that started it.
- R7: A maint_wr pulse while mdio_idle is 0 is ignored: the frame in flight and maint_rdata are both unchanged.
- R8: While port_en is 0, mdc does not toggle and commands are ignored. If port_en drops in the middle of a frame, the frame pauses and resumes when port_en returns.
- R9: With div_half = H, MDC spends H clocks high and H clocks low, a period of 2H clocks. H = 0 behaves as H = 1, and H = 112 gives divide-by-224.
- R10: A maint_wr pulse whose operation field is 2'b00 or 2'b11 is ignored: mdio_idle stays 1 and maint_rdata is unchanged.
- R11: Whenever mdio_idle is 1, mdc is 0 and mdio_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Management port enable; no MDC activity while low |
| div_half | input | DIV_W | MDC half period in system clocks (0 acts as 1) |
| maint_wr | input | 1 | Write strobe for the maintenance word |
| maint_wdata | input | 32 | Maintenance word: op 29:28, PHY 27:23, register 22:18, data 15:0 |
| maint_rdata | output | 32 | Maintenance word read back; low half holds read data after a read |
| mdio_idle | output | 1 | High when no frame is in flight |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the PHY |

## Verification
The assertions assume that div_half and the operation field stay constant while a frame is in flight. They also assume that mdio_i is driven by a PHY that changes it only after MDC falls. The bench changes div_half only while mdio_idle is high, and its PHY model drives the reply on MDC falling edges. The one deliberate exception is the check that a maintenance write during a busy frame is ignored, which compares the frame on the wire and the read-back word with the first command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS    = 64;
  localparam int BIT_W         = $clog2(FRAME_BITS);
  localparam int PREAMBLE_BITS = 32;
  localparam int DATA_BITS     = 16;
  localparam int TA_FIRST      = FRAME_BITS - DATA_BITS - 2;
  localparam int DATA_FIRST    = FRAME_BITS - DATA_BITS;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } frame_state_e;

  typedef struct packed {
    logic [1:0]  spare;
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [1:0]  pad;
    logic [15:0] data;
  } maint_word_t;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic [DIV_W-1:0] half;
  logic             mdc_q, mdc_n;
  logic             wrap;

  always_comb begin
    half = (div_half == '0) ? DIV_W'(1) : div_half;
    wrap = run && (cnt_q == half - DIV_W'(1));
  end

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (clr) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (run) begin
      if (wrap) begin
        cnt_n = '0;
        mdc_n = ~mdc_q;
      end else begin
        cnt_n = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_is_read,
  input  logic [FRAME_BITS-1:0] frame_word,
  input  logic                  rise_tick,
  input  logic                  fall_tick,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  done,
  output logic                  done_read,
  output logic [DATA_BITS-1:0]  rd_data,
  output logic                  mdio_o,
  output logic                  mdio_oe
);

  frame_state_e          state_q, state_n;
  logic [FRAME_BITS-1:0] sreg_q, sreg_n;
  logic [BIT_W-1:0]      bit_q, bit_n;
  logic                  rd_q, rd_n;
  logic [DATA_BITS-1:0]  sh_q, sh_n;
  logic                  last_bit;

  assign last_bit = (bit_q == BIT_W'(FRAME_BITS - 1));

  always_comb begin
    state_n = state_q;
    sreg_n  = sreg_q;
    bit_n   = bit_q;
    rd_n    = rd_q;
    sh_n    = sh_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_SHIFT;
          sreg_n  = frame_word;
          bit_n   = '0;
          rd_n    = start_is_read;
          sh_n    = '0;
        end
      end
      ST_SHIFT: begin
        if (rise_tick && rd_q && (bit_q >= BIT_W'(DATA_FIRST))) begin
          sh_n = {sh_q[DATA_BITS-2:0], mdio_i};
        end
        if (fall_tick) begin
          sreg_n = {sreg_q[FRAME_BITS-2:0], 1'b0};
          if (last_bit) begin
            state_n = ST_IDLE;
          end else begin
            bit_n = bit_q + BIT_W'(1);
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      sh_q    <= '0;
    end else begin
      state_q <= state_n;
      sreg_q  <= sreg_n;
      bit_q   <= bit_n;
      rd_q    <= rd_n;
      sh_q    <= sh_n;
    end
  end

  assign busy      = (state_q == ST_SHIFT);
  assign done      = busy && fall_tick && last_bit;
  assign done_read = done && rd_q;
  assign rd_data   = sh_q;
  assign mdio_o    = busy && sreg_q[FRAME_BITS-1];
  assign mdio_oe   = busy && !(rd_q && (bit_q >= BIT_W'(TA_FIRST)));

endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  maint_wr,
  input  logic [31:0]           maint_wdata,
  input  logic                  port_en,
  input  logic                  eng_busy,
  input  logic                  done_read,
  input  logic [DATA_BITS-1:0]  rd_data,
  output logic                  start,
  output logic                  start_is_read,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic [31:0]           maint_rdata
);

  maint_word_t cmd;
  logic [31:0] word_q, word_n;
  logic        op_ok;

  assign cmd = maint_word_t'(maint_wdata);

  always_comb begin
    op_ok         = (cmd.op == OP_WRITE) || (cmd.op == OP_READ);
    start         = maint_wr && port_en && !eng_busy && op_ok;
    start_is_read = (cmd.op == OP_READ);
    frame_word    = {{PREAMBLE_BITS{1'b1}}, 2'b01, cmd.op, cmd.phy,
                     cmd.regad, 2'b10, cmd.data};
  end

  always_comb begin
    word_n = word_q;
    if (start) begin
      word_n = maint_wdata;
    end else if (done_read) begin
      word_n = {word_q[31:DATA_BITS], rd_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else begin
      word_q <= word_n;
    end
  end

  assign maint_rdata = word_q;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic [DIV_W-1:0] div_half,
  input  logic             maint_wr,
  input  logic [31:0]      maint_wdata,
  output logic [31:0]      maint_rdata,
  output logic             mdio_idle,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);

  logic                  start, start_is_read;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  busy, done, done_read;
  logic [DATA_BITS-1:0]  rd_data;
  logic                  rise_tick, fall_tick;

  mdio_cmd_reg u_cmd (
    .clk           (clk),
    .rst_n         (rst_n),
    .maint_wr      (maint_wr),
    .maint_wdata   (maint_wdata),
    .port_en       (port_en),
    .eng_busy      (busy),
    .done_read     (done_read),
    .rd_data       (rd_data),
    .start         (start),
    .start_is_read (start_is_read),
    .frame_word    (frame_word),
    .maint_rdata   (maint_rdata)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (!busy || done),
    .run       (busy && port_en),
    .div_half  (div_half),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_eng u_eng (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .start_is_read (start_is_read),
    .frame_word    (frame_word),
    .rise_tick     (rise_tick),
    .fall_tick     (fall_tick),
    .mdio_i        (mdio_i),
    .busy          (busy),
    .done          (done),
    .done_read     (done_read),
    .rd_data       (rd_data),
    .mdio_o        (mdio_o),
    .mdio_oe       (mdio_oe)
  );

  assign mdio_idle = !busy;

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        port_en,
  input logic        maint_wr,
  input logic [31:0] maint_rdata,
  input logic        mdio_idle,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_idle |-> (!mdc && !mdio_oe)); // R11

  AST_DISABLED_NO_MDC: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> $stable(mdc)); // R8

  AST_MDIO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> ($fell(mdc) || $fell(mdio_idle))); // R3

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (maint_wr && !mdio_idle && !mdc) |=> $stable(maint_rdata)); // R7

  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdio_idle && !mdc) |=> !mdio_idle); // R2

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_en     (port_en),
  .maint_wr    (maint_wr),
  .maint_rdata (maint_rdata),
  .mdio_idle   (mdio_idle),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe)
);

// File: tb/mdio_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_ctrl_bench;

  localparam int DIV_W = 8;

  logic             clk;
  logic             rst_n;
  logic             port_en;
  logic [DIV_W-1:0] div_half;
  logic             maint_wr;
  logic [31:0]      maint_wdata;
  logic [31:0]      maint_rdata;
  logic             mdio_idle, mdc, mdio_o, mdio_oe;
  logic             mdio_i;

  int n_tests = 0;
  int n_fail  = 0;

  int          rcnt;
  logic [63:0] got_o, got_oe;
  realtime     t_rise [0:3];
  logic [15:0] phy_val;

  mdio_mgmt_ctrl #(.DIV_W(DIV_W)) u_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_half(div_half),
    .maint_wr(maint_wr), .maint_wdata(maint_wdata), .maint_rdata(maint_rdata),
    .mdio_idle(mdio_idle), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Monitor sampling the wire on MDC rising edges
  initial begin
    forever begin
      @(posedge mdc);
      if (rcnt < 64) begin
        got_o[63-rcnt]  = mdio_o;
        got_oe[63-rcnt] = mdio_oe;
      end
      if (rcnt < 4) t_rise[rcnt] = $realtime;
      rcnt = rcnt + 1;
    end
  end

  // PHY model: drives the reply after MDC falls
  initial begin
    mdio_i = 1'b0;
    forever begin
      @(negedge mdc);
      if (rcnt >= 48 && rcnt < 64) mdio_i = phy_val[15-(rcnt-48)];
      else mdio_i = 1'b0;
    end
  end

  initial begin
    #5_000_000;
    n_fail = n_fail + 1;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests = n_tests + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b00, op, phy, ra, 2'b00, d};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    return {32'hFFFF_FFFF, 2'b01, w[29:28], w[27:23], w[22:18], 2'b10, w[15:0]};
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    maint_wdata = w;
    maint_wr    = 1'b1;
    @(negedge clk);
    maint_wr    = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40000 && !mdio_idle; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; port_en = 1'b1; div_half = 8'd4; maint_wr = 1'b0;
    maint_wdata = '0; phy_val = '0; rcnt = 0;
    repeat (3) @(negedge clk);
    check("R1 idle", 64'(mdio_idle), 64'd1);
    check("R1 mdc", 64'(mdc), 64'd0);
    check("R1 oe", 64'(mdio_oe), 64'd0);
    check("R1 rdata", 64'(maint_rdata), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_write();
    logic [31:0] w = mk(2'b01, 5'h15, 5'h0A, 16'hC3A5);
    rcnt = 0;
    issue(w);
    check("R2 idle low after accept", 64'(mdio_idle), 64'd0);
    check("R4 oe at first bit", 64'(mdio_oe), 64'd1);
    wait_idle();
    @(negedge clk);
    check("R3 rising edges per frame", 64'(rcnt), 64'd64);
    check("R3 R4 write frame bits", got_o, exp_frame(w));
    check("R4 oe across write", got_oe, {64{1'b1}});
    check("R6 readback after write", 64'(maint_rdata), 64'(w));
    check("R11 mdc low when idle", 64'(mdc), 64'd0);
  endtask

  task automatic t_read(input logic [15:0] val);
    logic [31:0] w = mk(2'b10, 5'h01, 5'h1F, 16'h0000);
    rcnt = 0; phy_val = val;
    issue(w);
    wait_idle();
    @(negedge clk);
    check("R3 read header bits", 64'(got_o[63:18]), 64'(exp_frame(w) >> 18));
    check("R5 oe pattern on read", got_oe, {{46{1'b1}}, 18'd0});
    check("R5 read data low half", 64'(maint_rdata[15:0]), 64'(val));
    check("R5 upper half as written", 64'(maint_rdata[31:16]), 64'(w[31:16]));
    check("R11 oe low when idle", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] a = mk(2'b01, 5'h03, 5'h04, 16'h1234);
    logic [31:0] b = mk(2'b10, 5'h1C, 5'h11, 16'hFFFF);
    rcnt = 0;
    issue(a);
    repeat (60) @(negedge clk);
    issue(b);
    check("R7 still busy", 64'(mdio_idle), 64'd0);
    check("R7 readback unchanged mid-frame", 64'(maint_rdata), 64'(a));
    wait_idle();
    @(negedge clk);
    check("R7 frame of first command", got_o, exp_frame(a));
    check("R7 final readback", 64'(maint_rdata), 64'(a));
  endtask

  task automatic t_enable();
    logic [31:0] w = mk(2'b01, 5'h0F, 5'h10, 16'h5AA5);
    logic        m;
    int          r;
    port_en = 1'b0; rcnt = 0;
    issue(w);
    repeat (40) @(negedge clk);
    check("R8 command ignored when disabled", 64'(mdio_idle), 64'd1);
    check("R8 no mdc edges when disabled", 64'(rcnt), 64'd0);
    port_en = 1'b1;
    issue(w);
    repeat (70) @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    m = mdc; r = rcnt;
    repeat (50) @(negedge clk);
    check("R8 mdc frozen", 64'(mdc), 64'(m));
    check("R8 no edges while paused", 64'(rcnt), 64'(r));
    check("R8 frame still pending", 64'(mdio_idle), 64'd0);
    port_en = 1'b1;
    wait_idle();
    @(negedge clk);
    check("R8 resumed frame complete", got_o, exp_frame(w));
  endtask

  task automatic t_bad_op();
    logic [31:0] prev = maint_rdata;
    issue(mk(2'b00, 5'h01, 5'h02, 16'hAAAA));
    check("R10 op 00 ignored", 64'(mdio_idle), 64'd1);
    issue(mk(2'b11, 5'h01, 5'h02, 16'hAAAA));
    check("R10 op 11 ignored", 64'(mdio_idle), 64'd1);
    check("R10 readback unchanged", 64'(maint_rdata), 64'(prev));
  endtask

  task automatic t_divider(input logic [7:0] h, input int exp_clks);
    div_half = h; rcnt = 0;
    issue(mk(2'b01, 5'h02, 5'h02, 16'h0F0F));
    while (rcnt < 3) @(negedge clk);
    check($sformatf("R9 mdc period for half %0d", h),
          64'(int'((t_rise[2] - t_rise[1]) / 4.0)), 64'(exp_clks));
    wait_idle();
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_write();
    t_read(16'hB00C);
    t_read(16'h0001);
    t_busy_ignore();
    t_enable();
    t_bad_op();
    t_divider(8'd0, 2);
    t_divider(8'd5, 10);
    t_divider(8'd112, 224);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule